// File: doc/BRIEF.md
# Bi-phase-level Manchester encoder

This block merges a serial data stream and its bit timing into a single bi-phase-level line signal. It also drives the exact complement of that signal on a second pin. It runs on a core clock at twice the bit rate. A one-cycle cell strobe marks the first half of every bit cell. A bit cell is therefore two core cycles, and a 100 MHz core clock carries 50 Mbaud.

The data input is captured only on the strobe and held for the whole cell. In the first half of the cell the line carries the captured bit. In the second half it carries the inverse of that bit. As a result, every cell has a transition at its middle whose direction gives the bit value.

Both outputs come straight from flip-flops that are updated on the same edge, so the pair switches together and without glitches. A synchronous active-low reset parks the line in an idle state. The line stays idle until the first strobe after the reset is released.

Top module: `manch_encoder`

## Requirements
- R1: A captured bit of 1 drives `line_out` high for the first core cycle of the cell and low for the second (falling transition at mid-cell).
- R2: A captured bit of 0 drives `line_out` low for the first core cycle of the cell and high for the second (rising transition at mid-cell).
- R3: A cell begins on the core clock edge at which `cell_strobe` is 1. The first-half level is visible in the cycle that follows that edge, and the second-half level in the cycle after that.
- R4: `line_out_n` is the logical inverse of `line_out` in every cycle, including during reset and idle.
- R5: While `rst_n` is 0 at a clock edge, the encoder goes idle: `line_out` = 0 and `line_out_n` = 1. This holds even in the middle of a cell.
- R6: After reset is released, the outputs keep the idle levels until the first edge at which `cell_strobe` is 1.
- R7: `data_in` is sampled only when `cell_strobe` is 1. Changes to it at other times do not alter the current cell's output.
- R8: If no strobe follows a second half, the outputs hold the second-half level until the next strobe.
- R9: A strobe in the cycle right after a strobe starts a new cell at once. The pending second half of the earlier cell is dropped.
- R10: Between two consecutive cells, `line_out` changes at the cell boundary when the two bits are equal and stays put when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_strobe | input | 1 | One-cycle marker of a cell's first half; data is sampled here |
| data_in | input | 1 | Serial data bit |
| line_out | output | 1 | Bi-phase-level line signal |
| line_out_n | output | 1 | Complement of `line_out` |

## Verification
The encoder is fed every 6-bit word. This covers every ordered pair of neighbouring bits, so a swapped half-cell polarity is separated from a missing or extra boundary edge. Streams in which `data_in` flips right after each strobe show whether the input is sampled once or followed through the cell. Gaps between strobes, two strobes back to back, and a reset asserted mid-cell test the hold level, the restart of a cell and the override to idle. Each of these would look the same under plain continuous traffic.

// File: rtl/me_pkg.sv
package me_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  // Line level for one half of a cell: the bit itself, then its inverse.
  function automatic logic half_level(input logic bit_val, input logic second);
    return second ? ~bit_val : bit_val;
  endfunction
endpackage

// File: rtl/me_phase.sv
module me_phase
  import me_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strobe,
  output phase_e phase_q
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (strobe)                  phase_d = PH_FIRST;
    else if (phase_q == PH_FIRST) phase_d = PH_SECOND;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/me_sampler.sv
module me_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic data_in,
  output logic held_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (strobe) held_q <= data_in;
  end
endmodule

// File: rtl/me_driver.sv
module me_driver
  import me_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   strobe,
  input  logic   data_in,
  input  phase_e phase,
  input  logic   held,
  output logic   line_q,
  output logic   line_n_q
);
  logic next_lvl;
  logic load;

  always_comb begin
    load     = 1'b0;
    next_lvl = line_q;
    if (strobe) begin
      load     = 1'b1;
      next_lvl = half_level(data_in, 1'b0);
    end else if (phase == PH_FIRST) begin
      load     = 1'b1;
      next_lvl = half_level(held, 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q   <= IDLE_LEVEL;
      line_n_q <= ~IDLE_LEVEL;
    end else if (load) begin
      line_q   <= next_lvl;
      line_n_q <= ~next_lvl;
    end
  end
endmodule

// File: rtl/manch_encoder.sv
module manch_encoder
  import me_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_strobe,
  input  logic data_in,
  output logic line_out,
  output logic line_out_n
);
  phase_e phase;
  logic   held_bit;

  me_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (cell_strobe),
    .phase_q (phase)
  );

  me_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (cell_strobe),
    .data_in (data_in),
    .held_q  (held_bit)
  );

  me_driver #(.IDLE_LEVEL(IDLE_LEVEL)) u_driver (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (cell_strobe),
    .data_in  (data_in),
    .phase    (phase),
    .held     (held_bit),
    .line_q   (line_out),
    .line_n_q (line_out_n)
  );
endmodule

// File: rtl/manch_encoder_chk.sv
module manch_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_strobe,
  input logic data_in,
  input logic line_out,
  input logic line_out_n
);
  logic       seen_q;
  logic [1:0] armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      armed_q <= 2'd0;
    end else begin
      seen_q  <= seen_q | cell_strobe;
      if (armed_q != 2'd3) armed_q <= armed_q + 2'd1;
    end
  end

  // R4
  compl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_out_n == ~line_out);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (line_out == 1'b0));

  // R3
  first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_strobe |=> (line_out == $past(data_in)));

  // R1 R2 R7
  second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q == 2'd3 && $past(cell_strobe) && !cell_strobe)
      |=> (line_out == ~$past(data_in, 2)));

  // R8
  gap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q == 2'd3 && !$past(cell_strobe) && !cell_strobe) |=> $stable(line_out));
endmodule

bind manch_encoder manch_encoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cell_strobe (cell_strobe),
  .data_in     (data_in),
  .line_out    (line_out),
  .line_out_n  (line_out_n)
);

// File: tb/manch_encoder_tb.sv
module manch_encoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_strobe = 1'b0;
  logic data_in = 1'b0;
  logic line_out, line_out_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic have_prev = 1'b0;
  logic prev_bit = 1'b0;

  always #10 clk = ~clk;

  manch_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .cell_strobe(cell_strobe),
    .data_in(data_in), .line_out(line_out), .line_out_n(line_out_n)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Entered and left at a negative edge; one cell is two core cycles.
  task automatic send_cell(input logic d);
    cell_strobe = 1'b1;
    data_in = d;
    @(negedge clk);
    chk(line_out, d, d ? "R1 first half" : "R2 first half");
    chk(line_out_n, ~d, "R4 first half");
    if (have_prev)
      chk(line_out != ~prev_bit, d == prev_bit, "R10 boundary edge");
    cell_strobe = 1'b0;
    data_in = ~d;  // R7: a late change must not reach this cell
    @(negedge clk);
    chk(line_out, ~d, d ? "R1/R7 second half" : "R2/R7 second half");
    chk(line_out_n, d, "R4 second half");
    have_prev = 1'b1;
    prev_bit = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_out, 1'b0, "R5 reset line");
    chk(line_out_n, 1'b1, "R5/R4 reset inverse");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      data_in = i[0];
      @(negedge clk);
      chk(line_out, 1'b0, "R6 idle before strobe");
      chk(line_out_n, 1'b1, "R6/R4 idle inverse");
    end

    // R3 R10: every 6-bit word, cells back to back
    for (int w = 0; w < 64; w++)
      for (int b = 0; b < 6; b++)
        send_cell(w[b]);

    // R8: gap after a cell holds the second-half level
    send_cell(1'b1);
    for (int i = 0; i < 3; i++) begin
      data_in = i[0];
      @(negedge clk);
      chk(line_out, 1'b0, "R8 hold after one");
    end
    send_cell(1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(line_out, 1'b1, "R8 hold after zero");
    end

    // R9: back-to-back strobes restart the cell
    cell_strobe = 1'b1;
    data_in = 1'b1;
    @(negedge clk);
    chk(line_out, 1'b1, "R9 first strobe");
    data_in = 1'b1;
    @(negedge clk);
    chk(line_out, 1'b1, "R9 restart drops second half");
    cell_strobe = 1'b0;
    @(negedge clk);
    chk(line_out, 1'b0, "R9 second half of new cell");
    have_prev = 1'b0;

    // pseudo-random stream
    for (int i = 0; i < 200; i++) send_cell(1'((i * 37 + (i >> 3)) % 3 == 1));

    // R5: reset mid-cell of a zero overrides the pending high half
    cell_strobe = 1'b1;
    data_in = 1'b0;
    @(negedge clk);
    cell_strobe = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(line_out, 1'b0, "R5 reset mid-cell");
    chk(line_out_n, 1'b1, "R5 reset mid-cell inverse");
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_out, 1'b0, "R6 idle after mid-cell reset");
    have_prev = 1'b0;
    send_cell(1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule